// File: doc/BRIEF.md
# ADSR Envelope Generator with Selectable Release Behaviour

This block produces the amplitude envelope of one synthesizer voice. A key gate input starts the envelope. The envelope then climbs through an attack segment, falls through a decay segment to a programmable sustain level, and holds there. When the key is let go, a release segment brings it back down to silence. Each moving segment has its own rate input. The output is an unsigned level, 16 bits wide by default, together with a 3-bit code that names the current stage.

Two control bits shape the behaviour. The first bit picks the release policy. With it clear, letting go of the key starts release at once, from whatever level the envelope has reached. With it set, the envelope always finishes attack and decay, and release begins only once the sustain level is reached. The second bit switches every segment from fixed linear steps to a curved shape. In that shape each step is a shifted fraction of the distance still to go, so the envelope slows down as it nears its target.

Gate edges are found inside the main clock domain, by comparing the gate with a registered copy of itself. The block advances one step on every clock. The surrounding logic scales the rates, or gates the clock enable, to set the real timing.

Top module: `env_adsr`

## Requirements
- R1: While reset is asserted, and right after it, the level is 0 and the stage is idle. The stage codes are idle=0, attack=1, decay=2, sustain=3, release=4. No other code ever appears.
- R2: A rising gate is the first clock edge on which gate is 1 after it was 0 on the previous edge. On that edge, from any stage, the stage becomes attack and the level stays unchanged.
- R3: In linear attack, each clock adds max(atk_rate,1) to the level, saturating at 0xFFFF. The edge that reaches 0xFFFF also moves the stage to decay.
- R4: In linear decay, each clock subtracts max(dec_rate,1) without going below sus_level. The edge that reaches sus_level moves the stage to sustain, and the level then holds while the gate stays high.
- R5: With keep_curve=0, a low gate during attack, decay or sustain moves the stage to release on the next edge, with the level held at its current value.
- R6: With keep_curve=1, a low gate does not leave attack or decay. Release starts on the edge after sustain is reached, if the gate is low then.
- R7: In release, each clock subtracts max(rel_rate,1) without going below 0. The edge that reaches 0 moves the stage to idle. In idle the level stays 0 until a rising gate.
- R8: With curve_exp=1, the step of every segment is the remaining distance to that segment's target, shifted right by the low 4 bits of the segment's rate. The step is never less than 1 and never larger than the remaining distance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one envelope step per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate | input | 1 | Key gate, high while the key is held |
| atk_rate | input | 16 | Attack step (linear) or shift in the low 4 bits (curved) |
| dec_rate | input | 16 | Decay step (linear) or shift in the low 4 bits (curved) |
| sus_level | input | 16 | Sustain level |
| rel_rate | input | 16 | Release step (linear) or shift in the low 4 bits (curved) |
| keep_curve | input | 1 | 1: complete attack and decay before release |
| curve_exp | input | 1 | 1: curved segments, 0: linear segments |
| level | output | 16 | Envelope level, unsigned |
| stage | output | 3 | Current stage code |

## Verification
The assertions guard these properties on every cycle:
- The stage code is legal.
- Attack never lowers the level, and release never raises it.
- Decay never falls below the sustain level it was given.
- Idle always outputs zero.
- A rising gate restarts attack without moving the level.
- In full-curve mode, attack always stays in attack or hands over to decay.

Some behaviour only the bench scenarios can show:
- the exact step sizes and the edge on which each saturation point is hit;
- the values of the curved shape and its minimum step;
- the held level at key-up in normal mode;
- the delayed release in full-curve mode.

// File: rtl/env_pkg.sv
package env_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_ATTACK  = 3'd1,
      ST_DECAY   = 3'd2,
      ST_SUSTAIN = 3'd3,
      ST_RELEASE = 3'd4
   } env_stage_e;

   localparam int unsigned SEG_N   = 3;
   localparam int unsigned SEG_ATK = 0;
   localparam int unsigned SEG_DEC = 1;
   localparam int unsigned SEG_REL = 2;
endpackage

// File: rtl/env_gate_edge.sv
module env_gate_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_i,
   output logic rise_o,
   output logic held_o
);
   logic gate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= gate_i;
   end

   assign rise_o = gate_i & ~gate_q;
   assign held_o = gate_q;

   // R2: a rise is reported for exactly one edge, then the copy is high
   assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> held_o);
endmodule

// File: rtl/env_step.sv
module env_step #(
   parameter int unsigned LEVEL_W = 16,
   parameter int unsigned RATE_W  = 16
) (
   input  logic [LEVEL_W-1:0] dist_i,
   input  logic [RATE_W-1:0]  rate_i,
   input  logic               curve_i,
   output logic [LEVEL_W-1:0] step_o
);
   localparam int unsigned SHIFT_W = $clog2(LEVEL_W);

   logic [LEVEL_W-1:0] rate_ext;
   logic [LEVEL_W-1:0] lin_step;
   logic [LEVEL_W-1:0] nl_shift;
   logic [LEVEL_W-1:0] nl_step;
   logic [LEVEL_W-1:0] raw_step;

   if (RATE_W == LEVEL_W) begin : g_rate_full
      assign rate_ext = rate_i;
   end else begin : g_rate_pad
      assign rate_ext = {{(LEVEL_W-RATE_W){1'b0}}, rate_i};
   end

   always_comb begin
      lin_step = (rate_ext == '0) ? LEVEL_W'(1) : rate_ext;
      nl_shift = dist_i >> rate_i[SHIFT_W-1:0];
      nl_step  = (nl_shift == '0) ? LEVEL_W'(1) : nl_shift;
      raw_step = curve_i ? nl_step : lin_step;
      step_o   = (raw_step > dist_i) ? dist_i : raw_step;
   end
endmodule

// File: rtl/env_adsr.sv
module env_adsr #(
   parameter int unsigned LEVEL_W = 16,
   parameter int unsigned RATE_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               gate,
   input  logic [RATE_W-1:0]  atk_rate,
   input  logic [RATE_W-1:0]  dec_rate,
   input  logic [LEVEL_W-1:0] sus_level,
   input  logic [RATE_W-1:0]  rel_rate,
   input  logic               keep_curve,
   input  logic               curve_exp,
   output logic [LEVEL_W-1:0] level,
   output logic [2:0]         stage
);
   import env_pkg::*;

   localparam int unsigned         SHIFT_W = $clog2(LEVEL_W);
   localparam logic [LEVEL_W-1:0]  FULL    = {LEVEL_W{1'b1}};

   if (LEVEL_W < 4) begin : g_bad_level
      $error("env_adsr: LEVEL_W must be at least 4");
   end
   if (RATE_W > LEVEL_W || RATE_W < SHIFT_W) begin : g_bad_rate
      $error("env_adsr: RATE_W must lie between clog2(LEVEL_W) and LEVEL_W");
   end

   logic               rise;
   logic               gate_held;
   logic [LEVEL_W-1:0] level_q, level_d;
   env_stage_e         stage_q, stage_d;
   logic [LEVEL_W-1:0] seg_dist [SEG_N];
   logic [RATE_W-1:0]  seg_rate [SEG_N];
   logic [LEVEL_W-1:0] seg_step [SEG_N];

   env_gate_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .gate_i (gate),
      .rise_o (rise),
      .held_o (gate_held)
   );

   always_comb begin
      seg_dist[SEG_ATK] = FULL - level_q;
      seg_dist[SEG_DEC] = (level_q > sus_level) ? (level_q - sus_level) : '0;
      seg_dist[SEG_REL] = level_q;
      seg_rate[SEG_ATK] = atk_rate;
      seg_rate[SEG_DEC] = dec_rate;
      seg_rate[SEG_REL] = rel_rate;
   end

   for (genvar s = 0; s < SEG_N; s++) begin : g_seg
      env_step #(.LEVEL_W(LEVEL_W), .RATE_W(RATE_W)) u_step (
         .dist_i  (seg_dist[s]),
         .rate_i  (seg_rate[s]),
         .curve_i (curve_exp),
         .step_o  (seg_step[s])
      );
   end

   always_comb begin
      level_d = level_q;
      stage_d = stage_q;
      if (rise) begin
         stage_d = ST_ATTACK;
      end else begin
         unique case (stage_q)
            ST_IDLE: level_d = '0;
            ST_ATTACK: begin
               if (!gate && !keep_curve) begin
                  stage_d = ST_RELEASE;
               end else begin
                  level_d = level_q + seg_step[SEG_ATK];
                  if (level_d == FULL) stage_d = ST_DECAY;
               end
            end
            ST_DECAY: begin
               if (!gate && !keep_curve) begin
                  stage_d = ST_RELEASE;
               end else begin
                  level_d = level_q - seg_step[SEG_DEC];
                  if (level_d <= sus_level) stage_d = ST_SUSTAIN;
               end
            end
            ST_SUSTAIN: if (!gate) stage_d = ST_RELEASE;
            ST_RELEASE: begin
               level_d = level_q - seg_step[SEG_REL];
               if (level_d == '0) stage_d = ST_IDLE;
            end
            default: begin
               stage_d = ST_IDLE;
               level_d = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
         stage_q <= ST_IDLE;
      end else begin
         level_q <= level_d;
         stage_q <= stage_d;
      end
   end

   assign level = level_q;
   assign stage = stage_q;

   assert_stage_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stage_q inside {ST_IDLE, ST_ATTACK, ST_DECAY, ST_SUSTAIN, ST_RELEASE});

   assert_retrigger_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && gate_held == 1'b0) |=> (stage_q == ST_ATTACK && level_q == $past(level_q)));

   assert_attack_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q == ST_ATTACK) |=> level_q >= $past(level_q));

   assert_decay_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q == ST_DECAY && level_q > sus_level) |=> level_q >= $past(sus_level));

   assert_full_curve_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (keep_curve && stage_q == ST_ATTACK) |=> (stage_q == ST_ATTACK || stage_q == ST_DECAY));

   assert_release_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q == ST_RELEASE) |=> level_q <= $past(level_q));

   assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q == ST_IDLE) |-> level_q == '0);

   assert_step_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q == ST_RELEASE && level_q != '0) |-> (seg_step[SEG_REL] != '0 && seg_step[SEG_REL] <= level_q));
endmodule

// File: tb/sim_env_adsr.sv
module sim_env_adsr;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        gate = 1'b0;
   logic [15:0] atk_rate = '0, dec_rate = '0, sus_level = '0, rel_rate = '0;
   logic        keep_curve = 1'b0, curve_exp = 1'b0;
   logic [15:0] level;
   logic [2:0]  stage;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   env_adsr u0 (
      .clk(clk), .rst_n(rst_n), .gate(gate),
      .atk_rate(atk_rate), .dec_rate(dec_rate), .sus_level(sus_level),
      .rel_rate(rel_rate), .keep_curve(keep_curve), .curve_exp(curve_exp),
      .level(level), .stage(stage)
   );

   typedef struct packed {
      logic [15:0] a;
      logic [15:0] d;
      logic [15:0] s;
      logic [7:0]  n;
      logic [15:0] lvl;
      logic [2:0]  stg;
   } vec_t;

   // linear runs with the gate held high for n edges (edge 1 is the rise)
   localparam vec_t VECS [5] = '{
      '{16'h1000, 16'h0000, 16'h0000, 8'd5, 16'h4000, 3'd1},
      '{16'h4000, 16'h0000, 16'h0000, 8'd5, 16'hFFFF, 3'd2},
      '{16'h8000, 16'h1000, 16'h8000, 8'd6, 16'hCFFF, 3'd2},
      '{16'hFFFF, 16'h4000, 16'h9000, 8'd8, 16'h9000, 3'd3},
      '{16'h0000, 16'h0000, 16'h0000, 8'd4, 16'h0003, 3'd1}
   };

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      gate = 1'b0;
      rst_n = 1'b0;
      tick(2);
      rst_n = 1'b1;
   endtask

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      tick(1);
      check("R1 reset level", level, 16'h0000);
      check("R1 reset stage", {13'd0, stage}, 16'd0);
      rst_n = 1'b1;

      foreach (VECS[i]) begin
         do_reset();
         atk_rate = VECS[i].a; dec_rate = VECS[i].d; sus_level = VECS[i].s;
         keep_curve = 1'b0; curve_exp = 1'b0;
         gate = 1'b1;
         tick(int'(VECS[i].n));
         check("R3/R4 vector level", level, VECS[i].lvl);
         check("R3/R4 vector stage", {13'd0, stage}, {13'd0, VECS[i].stg});
      end

      // R5 normal release from mid-attack, then R7 release to idle
      do_reset();
      atk_rate = 16'h1000; rel_rate = 16'h1000; sus_level = 16'h8000;
      gate = 1'b1; tick(5);
      gate = 1'b0; tick(1);
      check("R5 held level", level, 16'h4000);
      check("R5 release stage", {13'd0, stage}, 16'd4);
      tick(4);
      check("R7 reach zero", level, 16'h0000);
      check("R7 idle stage", {13'd0, stage}, 16'd0);
      tick(6);
      check("R7 idle stays zero", level, 16'h0000);

      // R2 retrigger during release
      gate = 1'b1; tick(5);
      gate = 1'b0; tick(2);
      check("R2 pre-retrigger level", level, 16'h3000);
      gate = 1'b1; tick(1);
      check("R2 retrigger stage", {13'd0, stage}, 16'd1);
      check("R2 retrigger level held", level, 16'h3000);
      tick(1);
      check("R2 attack resumes", level, 16'h4000);

      // R6 full-curve mode
      do_reset();
      keep_curve = 1'b1;
      atk_rate = 16'h1000; dec_rate = 16'h1000; sus_level = 16'hE000; rel_rate = 16'h1000;
      gate = 1'b1; tick(3);
      gate = 1'b0; tick(1);
      check("R6 attack continues level", level, 16'h3000);
      check("R6 attack continues stage", {13'd0, stage}, 16'd1);
      tick(15);
      check("R6 sustain reached level", level, 16'hE000);
      check("R6 sustain reached stage", {13'd0, stage}, 16'd3);
      tick(1);
      check("R6 release after sustain", {13'd0, stage}, 16'd4);
      check("R6 release starts at sustain", level, 16'hE000);
      keep_curve = 1'b0;

      // R8 curved shape
      do_reset();
      curve_exp = 1'b1; atk_rate = 16'h0002;
      gate = 1'b1; tick(3);
      check("R8 curved attack", level, 16'h6FFF);
      do_reset();
      atk_rate = 16'h000F;
      gate = 1'b1; tick(4);
      check("R8 minimum step", level, 16'h0003);
      curve_exp = 1'b0;

      // R1 reset in mid-run
      rst_n = 1'b0; tick(1);
      check("R1 mid-run reset", level, 16'h0000);
      rst_n = 1'b1;

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule